// File: doc/BRIEF.md
# Reset Release Sequencer with Cause Flags

This block decides when the rest of the chip may leave reset. Once every reset request has gone away, it keeps the chip held in reset for two waits in a row. The first is an optional long wait. It is counted in ticks of a slow timebase and only follows a reset. The second is a short wait counted in system clock cycles. A 2-bit start-up code sets both waits, and the active clock source (RC/external or PLL) decides what each code means. A wake-up from power-down uses the clock-cycle wait alone.

The block also keeps a byte-wide register of sticky cause flags, one flag for each reset source. Software reads the register to find out why the last reset happened. It clears a flag by writing 0 to that bit.

Top module: `rst_seq_flags`

## Requirements
- R1: A power-on request loads the flag register with 0x01. The power-on flag is bit 0, and all other flags are cleared.
- R2: The watchdog request sets bit 3, brown-out sets bit 2, and external sets bit 1. A set flag stays set after its request goes away. Bits 7..4 always read 0.
- R3: A write with `wr_en` clears every flag bit whose `wr_data` bit is 0. A 1 in `wr_data` leaves that bit unchanged. If a request arrives in the same cycle as a write that clears its bit, the flag is set.
- R4: `hold_rst` is high while any reset request is high, and it is high in the cycle that follows any request.
- R5: RC/external source (`pll_sel`=0), with `tb_tick` high every cycle: after the requests drop, `hold_rst` stays high for E+6 further cycles. E is 0 for code 00, TICKS_SHORT for code 01, and TICKS_LONG for code 10. Reserved code 11 behaves like code 10.
- R6: PLL source (`pll_sel`=1): the cycle count is CYC_PLL for codes 00, 01 and 10, with E equal to 0, TICKS_SHORT and TICKS_LONG respectively. Code 11 uses CYC_PLL_LONG cycles with E=0.
- R7: The extra reset delay advances only on cycles where `tb_tick` is high. The clock-cycle count starts after the extra delay ends.
- R8: A new reset request during the delay restarts the whole sequence from its beginning.
- R9: A `wake_req` pulse while the block is released holds `hold_rst` for exactly N cycles, where N is the clock-cycle count for the current source and code. No extra delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request; it also resets this block |
| bor_req | input | 1 | Brown-out reset request |
| ext_req | input | 1 | External pin reset request |
| wdt_req | input | 1 | Watchdog reset request |
| wake_req | input | 1 | Wake-up from power-down |
| sut_code | input | 2 | Start-up delay select code |
| pll_sel | input | 1 | 1 selects the PLL clock source, 0 selects RC/external |
| tb_tick | input | 1 | One-cycle tick from the slow timebase |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_data | input | 8 | Write data; a 0 bit clears the flag at that position |
| hold_rst | output | 1 | Internal reset held active |
| flags | output | 8 | Cause flags {0000, watchdog, brown-out, external, power-on} |

## Verification
The bench sweeps both clock sources and all four codes, after a reset and after a wake-up. It counts the hold cycles, so a design that skips the extra wait, counts the clock wait one cycle short or long, or gives reserved code 11 the wrong meaning shows up as a count mismatch. Further checks stop the timebase tick to catch a delay that runs freely, and inject a brown-out in the middle of the delay to catch a sequence that resumes instead of restarting. The flag checks cover clear-on-0 against no-effect-on-1, and a request arriving in the same cycle as a clearing write. They also check that power-on wipes the other causes, so a design that gives the write priority or lets power-on keep stale flags is caught.

// File: rtl/rst_seq_flags.sv
module rst_seq_flags #(
  parameter int TICKS_SHORT  = 41,
  parameter int TICKS_LONG   = 650,
  parameter int CYC_FAST     = 6,
  parameter int CYC_PLL      = 1024,
  parameter int CYC_PLL_LONG = 16384
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       bor_req,
  input  logic       ext_req,
  input  logic       wdt_req,
  input  logic       wake_req,
  input  logic [1:0] sut_code,
  input  logic       pll_sel,
  input  logic       tb_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       hold_rst,
  output logic [7:0] flags
);
  localparam int EW = $clog2(TICKS_LONG + 1);
  localparam int CW = $clog2(CYC_PLL_LONG + 1);

  typedef enum logic [1:0] {PH_DONE, PH_EXTRA, PH_CYC} phase_t;

  phase_t        phase;
  logic [EW-1:0] ext_left;
  logic [CW-1:0] cyc_left, cyc_load, cyc_sel;
  logic [EW-1:0] ext_sel;
  logic [7:0]    cause;
  logic          any_req;

  assign any_req  = por_req | bor_req | ext_req | wdt_req;
  assign hold_rst = any_req | (phase != PH_DONE);
  assign flags    = cause;

  always_comb begin
    case (sut_code)
      2'b00:   ext_sel = '0;
      2'b01:   ext_sel = EW'(TICKS_SHORT);
      2'b10:   ext_sel = EW'(TICKS_LONG);
      default: ext_sel = pll_sel ? '0 : EW'(TICKS_LONG);
    endcase
    if (!pll_sel)              cyc_sel = CW'(CYC_FAST);
    else if (sut_code == 2'b11) cyc_sel = CW'(CYC_PLL_LONG);
    else                       cyc_sel = CW'(CYC_PLL);
  end

  always_ff @(posedge clk) begin
    if (any_req) begin
      phase    <= PH_EXTRA;
      ext_left <= ext_sel;
      cyc_load <= cyc_sel;
    end else begin
      case (phase)
        PH_EXTRA:
          if (ext_left == '0) begin
            phase    <= PH_CYC;
            cyc_left <= cyc_load - 1'b1;
          end else if (tb_tick) begin
            ext_left <= ext_left - 1'b1;
          end
        PH_CYC:
          if (cyc_left == '0) phase <= PH_DONE;
          else                cyc_left <= cyc_left - 1'b1;
        PH_DONE:
          if (wake_req) begin
            phase    <= PH_CYC;
            cyc_left <= cyc_sel - 1'b1;
          end
        default: phase <= PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_req) cause <= 8'h01;
    else cause <= ((cause & (wr_en ? wr_data : 8'hFF))
                   | {4'b0, wdt_req, bor_req, ext_req, 1'b0}) & 8'h0F;
  end

  // R1
  por_flag_chk: assert property (@(posedge clk) por_req |=> flags[3:0] == 4'b0001);

  // R2
  wdt_sticky_chk: assert property (@(posedge clk) disable iff (por_req)
    wdt_req |=> flags[3]);

  // R3
  write_one_keep_chk: assert property (@(posedge clk) disable iff (por_req)
    (wr_en && wr_data[2] && flags[2]) |=> flags[2]);

  // R3
  write_zero_clr_chk: assert property (@(posedge clk) disable iff (por_req)
    (wr_en && !wr_data[1] && !ext_req) |=> !flags[1]);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (por_req)
    (bor_req || ext_req || wdt_req) |=> hold_rst);

  // R7
  no_tick_stall_chk: assert property (@(posedge clk) disable iff (por_req)
    (phase == PH_EXTRA && ext_left != '0 && !tb_tick && !any_req) |=> $stable(ext_left));
endmodule

// File: tb/rst_seq_flags_tb.sv
module rst_seq_flags_tb_top;
  localparam int TS = 3, TL = 7, CF = 6, CP = 20, CPL = 40;

  logic clk = 0, por_req = 1, bor_req = 0, ext_req = 0, wdt_req = 0, wake_req = 0;
  logic [1:0] sut_code = 0;
  logic pll_sel = 0, tb_tick = 1, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic hold_rst;
  logic [7:0] flags;
  int checks = 0, fails = 0;

  rst_seq_flags #(.TICKS_SHORT(TS), .TICKS_LONG(TL), .CYC_FAST(CF),
                  .CYC_PLL(CP), .CYC_PLL_LONG(CPL)) dut_i (
    .clk, .por_req, .bor_req, .ext_req, .wdt_req, .wake_req, .sut_code,
    .pll_sel, .tb_tick, .wr_en, .wr_data, .hold_rst, .flags);

  always #5 clk = ~clk;

  function automatic int exp_e(input logic p, input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return TS;
      2'd2: return TL;
      default: return p ? 0 : TL;
    endcase
  endfunction

  function automatic int exp_n(input logic p, input logic [1:0] c);
    if (!p) return CF;
    return (c == 2'd3) ? CPL : CP;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_hold(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!hold_rst || n > 5000) break;
      n++;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0; @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0; @(negedge clk);
  endtask

  task automatic run_reset(output int n);
    ext_req = 1; @(negedge clk); @(negedge clk);
    ext_req = 0;
    count_hold(n);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(flags == 8'h01, "R1 power-on flags", flags, 8'h01);
    chk(hold_rst == 1'b1, "R4 hold during power-on", hold_rst, 1);
    por_req = 0;
    count_hold(n);
    chk(n == exp_e(0, 0) + exp_n(0, 0), "R5 power-on release code00", n, exp_e(0,0)+exp_n(0,0));

    // R1 R2 R3 flag behaviour
    wr(8'h00);   chk(flags == 8'h00, "R3 write zero clears", flags, 0);
    pulse(wdt_req); chk(flags == 8'h08, "R2 watchdog sets bit3", flags, 8'h08);
    pulse(bor_req); chk(flags == 8'h0C, "R2 brown-out sets bit2", flags, 8'h0C);
    wr(8'hFF);   chk(flags == 8'h0C, "R3 write ones no effect, R2 upper zero", flags, 8'h0C);
    wr(8'hF7);   chk(flags == 8'h04, "R3 clear only bit3", flags, 8'h04);
    pulse(ext_req); chk(flags == 8'h06, "R2 external sets bit1", flags, 8'h06);
    wdt_req = 1; wr_en = 1; wr_data = 8'h00; @(negedge clk);
    wdt_req = 0; wr_en = 0; @(negedge clk);
    chk(flags == 8'h08, "R3 set wins over clear", flags, 8'h08);
    wr(8'hFE);   chk(flags == 8'h08, "R1 por flag clears by write only", flags, 8'h08);
    pulse(por_req); chk(flags == 8'h01, "R1 power-on wipes others", flags, 8'h01);
    count_hold(n);

    // R5 R6 sweep after reset and wake (R9)
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        pll_sel = p[0]; sut_code = 2'(c);
        ext_req = 1; @(negedge clk);
        chk(hold_rst == 1'b1, "R4 hold while requested", hold_rst, 1);
        @(negedge clk); ext_req = 0;
        count_hold(n);
        chk(n == exp_e(p[0], 2'(c)) + exp_n(p[0], 2'(c)),
            p ? "R6 PLL reset delay" : "R5 RC reset delay",
            n, exp_e(p[0], 2'(c)) + exp_n(p[0], 2'(c)));
        repeat (2) @(negedge clk);
        wake_req = 1; @(negedge clk); wake_req = 0;
        n = hold_rst ? 1 : 0;
        if (hold_rst) begin
          int m;
          count_hold(m);
          n += m;
        end
        chk(n == exp_n(p[0], 2'(c)), "R9 wake delay", n, exp_n(p[0], 2'(c)));
        repeat (2) @(negedge clk);
      end
    end

    // R7 tick gating
    pll_sel = 0; sut_code = 2'd1;
    ext_req = 1; @(negedge clk); tb_tick = 0; ext_req = 0;
    repeat (30) @(negedge clk);
    chk(hold_rst == 1'b1, "R7 held without ticks", hold_rst, 1);
    tb_tick = 1;
    count_hold(n);
    chk(n == TS + CF, "R7 delay after ticks resume", n, TS + CF);

    // R8 restart in mid sequence
    pll_sel = 1; sut_code = 2'd2;
    ext_req = 1; @(negedge clk); ext_req = 0;
    repeat (TL + 4) @(negedge clk);
    bor_req = 1; @(negedge clk); bor_req = 0;
    count_hold(n);
    chk(n == TL + CP, "R8 restart on new request", n, TL + CP);
    chk(flags[2] == 1'b1, "R8 R2 brown-out recorded", flags[2], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule